// File: doc/BRIEF.md
# Multi-Core Global Timer with Banked Comparators

The block keeps one free-running 64-bit count that all cores share, plus one comparator bank per core. The count advances once every (prescale + 1) clock cycles while the shared run bit is set. Each bank holds a 64-bit match value, a 32-bit re-arm step, a sticky event flag and a level interrupt line. A bank's event fires when the shared count has reached or passed its match value. If re-arm is on, the bank then moves its match value ahead of the count by whole steps, all in one cycle.

Software reaches the registers over a plain 32-bit word bus. A core-index input picks the bank that an access sees. Every core can read and load the shared count and can change the shared control fields. The 64-bit quantities are split into low and high words.

Top module: `gtmr_top`

## Requirements
- R1: While the run bit (control bit 0) is 1, the count rises by one on every (P+1)-th clock edge, where P is control bits 15:8. The count holds while the run bit is 0.
- R2: A bank raises its event when all three of these hold: the run bit is 1, its match-enable (control bit 1) is 1, and count >= match. The check runs every cycle, and the status flag is set on the clock edge after the condition first holds. A bank with match-enable 0 never sets its flag.
- R3: The status flag (word 3, bit 0) stays set until a write to word 3 has bit 0 = 1. A write with bit 0 = 0 leaves the flag unchanged. A new event in the same cycle as the clear wins over the clear.
- R4: The interrupt line of a bank equals its status flag ANDed with its interrupt-enable (control bit 2).
- R5: On an event with re-arm on (control bit 3) and a nonzero step (word 6), the match value grows by the smallest whole multiple of the step that puts it above the count. A zero step leaves the match value unchanged.
- R6: Writes to the count words (word 0 = low, word 1 = high) load the count only while the run bit is 0. They are ignored while it is 1.
- R7: Bits 1, 2 and 3 of control are kept per bank. The run bit and P are shared by all banks. A control read returns the shared fields ORed with the selected bank's bits.
- R8: Word map: 0 count low, 1 count high, 2 control, 3 status, 4 match low, 5 match high, 6 step. Word 7 reads as zero, and writes to it change nothing.
- R9: After reset, every register reads zero and every interrupt line is low.
- R10: The count is a true 64-bit value: a carry out of the low word reaches the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Word index inside the register window |
| bus_core | input | CORE_W | Bank picked by the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |
| irq_o | output | NCORE | Per-core level interrupt |

## Verification
Read data is combinational from the registers, so a read is due in the same cycle as its strobe. Writes take effect at the next edge. An event appears on the status flag and on the interrupt line one edge after the count reaches the match value. The count's k-th tick lands on the edge numbered k(P+1) after the run bit is set. Every check is placed at the negative edge that follows the exact edge the bench has counted. Several checks also sample one cycle early, to show a result is not there too soon.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 64;
    localparam int PRE_W   = 8;
    localparam int B_RUN   = 0;
    localparam int B_MATCH = 1;
    localparam int B_IRQ   = 2;
    localparam int B_REARM = 3;
    localparam int PRE_LSB = 8;

    typedef enum logic [2:0] {
        W_CNT_LO = 3'd0,
        W_CNT_HI = 3'd1,
        W_CTRL   = 3'd2,
        W_STAT   = 3'd3,
        W_CMP_LO = 3'd4,
        W_CMP_HI = 3'd5,
        W_STEP   = 3'd6,
        W_NONE   = 3'd7
    } word_e;

    typedef struct packed {
        logic match_en;
        logic irq_en;
        logic rearm_en;
    } bank_ctrl_t;
endpackage

// File: rtl/gtmr_prescale.sv
module gtmr_prescale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (!en) begin
            s_d.cnt = '0;
        end else if (s_q.cnt >= limit) begin
            tick    = 1'b1;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: an idle divider restarts from zero
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.cnt == '0));
endmodule

// File: rtl/gtmr_bank.sv
module gtmr_bank
    import gtmr_pkg::*;
#(
    parameter int CW = 64,
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] count,
    input  logic          ctrl_wr,
    input  logic          stat_wr,
    input  logic          cmp_lo_wr,
    input  logic          cmp_hi_wr,
    input  logic          step_wr,
    input  logic [WW-1:0] wdata,
    output bank_ctrl_t    ctrl_o,
    output logic          status_o,
    output logic [CW-1:0] cmp_o,
    output logic [WW-1:0] step_o,
    output logic          irq_o
);
    typedef struct packed {
        bank_ctrl_t    ctrl;
        logic          status;
        logic [CW-1:0] cmp;
        logic [WW-1:0] step;
    } bank_st_t;

    bank_st_t      s_d, s_q;
    logic          hit;
    logic [CW-1:0] gap;
    logic [CW-1:0] step_ext;
    logic [CW-1:0] advance;

    always_comb begin
        s_d      = s_q;
        hit      = run && s_q.ctrl.match_en && (count >= s_q.cmp);
        gap      = count - s_q.cmp;
        step_ext = (s_q.step == '0) ? CW'(1) : {{(CW-WW){1'b0}}, s_q.step};
        advance  = gap - (gap % step_ext) + step_ext;

        if (hit) begin
            s_d.status = 1'b1;
            if (s_q.ctrl.rearm_en && (s_q.step != '0)) begin
                s_d.cmp = s_q.cmp + advance;
            end
        end
        if (stat_wr && wdata[0] && !hit) begin
            s_d.status = 1'b0;
        end
        if (cmp_lo_wr) begin
            s_d.cmp = {s_q.cmp[CW-1:WW], wdata};
        end
        if (cmp_hi_wr) begin
            s_d.cmp = {wdata, s_q.cmp[WW-1:0]};
        end
        if (ctrl_wr) begin
            s_d.ctrl.match_en = wdata[B_MATCH];
            s_d.ctrl.irq_en   = wdata[B_IRQ];
            s_d.ctrl.rearm_en = wdata[B_REARM];
        end
        if (step_wr) begin
            s_d.step = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o   = s_q.ctrl;
    assign status_o = s_q.status;
    assign cmp_o    = s_q.cmp;
    assign step_o   = s_q.step;
    assign irq_o    = s_q.status && s_q.ctrl.irq_en;

    // R2: a match sets the flag on the next edge
    p_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> s_q.status);
    // R3: the flag only falls on a one-write to status
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.status && !(stat_wr && wdata[0])) |=> s_q.status);
    // R4: an enabled match drives the interrupt line
    p_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && s_q.ctrl.irq_en && !ctrl_wr) |=> irq_o);
    // R5: re-arm puts the match value above the count
    p_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && s_q.ctrl.rearm_en && (s_q.step != '0) && !cmp_lo_wr
         && !cmp_hi_wr && !count[CW-1] && !s_q.cmp[CW-1])
        |=> (s_q.cmp > $past(count)));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
    import gtmr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [2:0]        bus_word,
    input  logic [CORE_W-1:0] bus_core,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCORE-1:0]  irq_o
);
    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] presc;
        logic [CNT_W-1:0] count;
    } glob_st_t;

    glob_st_t s_d, s_q;
    word_e    wsel;
    logic     wr;
    logic     tick;
    logic     cnt_wr;

    bank_ctrl_t         b_ctrl [NCORE];
    logic               b_stat [NCORE];
    logic [CNT_W-1:0]   b_cmp  [NCORE];
    logic [WORD_W-1:0]  b_step [NCORE];

    assign wsel   = word_e'(bus_word);
    assign wr     = bus_sel && bus_we;
    assign cnt_wr = wr && ((wsel == W_CNT_LO) || (wsel == W_CNT_HI));

    gtmr_prescale #(.PW(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (s_q.run),
        .limit (s_q.presc),
        .tick  (tick)
    );

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.count = s_q.count + 1'b1;
        end
        if (!s_q.run && wr && (wsel == W_CNT_LO)) begin
            s_d.count = {s_q.count[CNT_W-1:WORD_W], bus_wdata};
        end
        if (!s_q.run && wr && (wsel == W_CNT_HI)) begin
            s_d.count = {bus_wdata, s_q.count[WORD_W-1:0]};
        end
        if (wr && (wsel == W_CTRL)) begin
            s_d.run   = bus_wdata[B_RUN];
            s_d.presc = bus_wdata[PRE_LSB +: PRE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NCORE; g++) begin : g_bank
        logic mine;
        assign mine = (bus_core == CORE_W'(g)) && wr;

        gtmr_bank #(.CW(CNT_W), .WW(WORD_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (s_q.run),
            .count     (s_q.count),
            .ctrl_wr   (mine && (wsel == W_CTRL)),
            .stat_wr   (mine && (wsel == W_STAT)),
            .cmp_lo_wr (mine && (wsel == W_CMP_LO)),
            .cmp_hi_wr (mine && (wsel == W_CMP_HI)),
            .step_wr   (mine && (wsel == W_STEP)),
            .wdata     (bus_wdata),
            .ctrl_o    (b_ctrl[g]),
            .status_o  (b_stat[g]),
            .cmp_o     (b_cmp[g]),
            .step_o    (b_step[g]),
            .irq_o     (irq_o[g])
        );
    end

    always_comb begin
        bank_ctrl_t        pc;
        logic              ps;
        logic [CNT_W-1:0]  pm;
        logic [WORD_W-1:0] pt;
        pc = '0;
        ps = 1'b0;
        pm = '0;
        pt = '0;
        for (int i = 0; i < NCORE; i++) begin
            if (bus_core == CORE_W'(i)) begin
                pc = b_ctrl[i];
                ps = b_stat[i];
                pm = b_cmp[i];
                pt = b_step[i];
            end
        end
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (wsel)
                W_CNT_LO: bus_rdata = s_q.count[WORD_W-1:0];
                W_CNT_HI: bus_rdata = s_q.count[CNT_W-1:WORD_W];
                W_CTRL:   bus_rdata = {16'b0, s_q.presc, 4'b0, pc.rearm_en,
                                       pc.irq_en, pc.match_en, s_q.run};
                W_STAT:   bus_rdata = {31'b0, ps};
                W_CMP_LO: bus_rdata = pm[WORD_W-1:0];
                W_CMP_HI: bus_rdata = pm[CNT_W-1:WORD_W];
                W_STEP:   bus_rdata = pt;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R1: while running the count moves by at most one per edge
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |=> ((s_q.count == $past(s_q.count))
                  || (s_q.count == $past(s_q.count) + 1'b1)));
    // R1: a stopped, unwritten count holds
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !cnt_wr) |=> $stable(s_q.count));
    // R6: a count write while running changes nothing
    p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && cnt_wr && !tick) |=> $stable(s_q.count));
endmodule

// File: tb/test_gtmr_top.sv
`timescale 1ns/1ps
module test_gtmr_top;
    localparam int NCORE  = 4;
    localparam int CORE_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [2:0]        bus_word = '0;
    logic [CORE_W-1:0] bus_core = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCORE-1:0]  irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        rd_evt;

    always #2 clk = ~clk;

    gtmr_top #(.NCORE(NCORE), .CORE_W(CORE_W)) i_gtmr_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_core  (bus_core),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic bus_wr(input int core, input int word, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_core = CORE_W'(core); bus_word = 3'(word); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input int core, input int word, input logic [31:0] e,
                          input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0;
        bus_core = CORE_W'(core); bus_word = 3'(word);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        #1 -> rd_evt;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input int idx, input logic e, input string tag);
        total++;
        if (irq_o[idx] !== e) begin
            bad++;
            $display("FAIL %s: irq[%0d] got %b expected %b", tag, idx, irq_o[idx], e);
        end
    endtask

    initial begin : monitor
        forever begin
            @(rd_evt);
            if (exp_q.size() != 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        bus_rd(0, 0, 32'h0, "R9 count lo");
        bus_rd(0, 1, 32'h0, "R9 count hi");
        bus_rd(0, 2, 32'h0, "R9 control");
        bus_rd(1, 3, 32'h0, "R9 status");
        bus_rd(2, 4, 32'h0, "R9 match lo");
        bus_rd(3, 6, 32'h0, "R9 step");
        for (int i = 0; i < NCORE; i++) chk_irq(i, 1'b0, "R9 irq");

        // R7: banked and shared control fields
        bus_wr(0, 2, 32'h0000_0004);
        bus_rd(1, 2, 32'h0000_0000, "R7 other bank clean");
        bus_rd(0, 2, 32'h0000_0004, "R7 own bank bits");
        bus_wr(1, 2, 32'h0000_0500);
        bus_rd(0, 2, 32'h0000_0504, "R7 shared prescale seen by bank0");
        bus_rd(1, 2, 32'h0000_0500, "R7 bank1 read");

        // R6: load while stopped, ignore while running
        bus_wr(1, 0, 32'hFFFF_FFF0);
        bus_wr(1, 1, 32'h0000_0001);
        bus_rd(1, 0, 32'hFFFF_FFF0, "R6 load lo");
        bus_rd(1, 1, 32'h0000_0001, "R6 load hi");
        bus_wr(1, 2, 32'h0000_FF01);
        bus_wr(1, 0, 32'h0000_1234);
        bus_wr(1, 2, 32'h0000_FF00);
        bus_rd(1, 0, 32'hFFFF_FFF0, "R6 write ignored while running");

        // R10: carry into high word (two edges at prescale 0)
        bus_wr(1, 0, 32'hFFFF_FFFF);
        bus_wr(1, 1, 32'h0000_0000);
        bus_wr(1, 2, 32'h0000_0001);
        bus_wr(1, 2, 32'h0000_0000);
        bus_rd(1, 1, 32'h0000_0001, "R10 carry hi");
        bus_rd(1, 0, 32'h0000_0001, "R10 carry lo");

        // R1: prescale 3, 21 running edges -> 5 ticks
        bus_wr(1, 0, 32'h0);
        bus_wr(1, 1, 32'h0);
        bus_wr(1, 2, 32'h0000_0301);
        repeat (19) @(negedge clk);
        bus_wr(1, 2, 32'h0000_0300);
        bus_rd(1, 0, 32'd5, "R1 prescaled count");
        repeat (10) @(negedge clk);
        bus_rd(1, 0, 32'd5, "R1 holds when stopped");

        // R2 R4: event at count >= 10, count starts at 5
        bus_wr(0, 0, 32'd5);
        bus_wr(0, 4, 32'd10);
        bus_wr(0, 5, 32'd0);
        bus_wr(0, 2, 32'h0000_0007);
        chk_irq(0, 1'b0, "R2 no early event");
        repeat (3) @(negedge clk);
        chk_irq(0, 1'b0, "R2 count 8 below match");
        repeat (4) @(negedge clk);
        chk_irq(0, 1'b1, "R2 event raised");
        chk_irq(1, 1'b0, "R2 disabled bank stays quiet");
        bus_wr(0, 2, 32'h0000_0006);
        bus_rd(1, 3, 32'h0, "R2 disabled bank status");
        bus_rd(0, 3, 32'h1, "R3 flag sticky after stop");
        bus_wr(0, 2, 32'h0000_0002);
        chk_irq(0, 1'b0, "R4 masked by irq enable");
        bus_rd(0, 3, 32'h1, "R4 status kept while masked");
        bus_wr(0, 2, 32'h0000_0006);
        chk_irq(0, 1'b1, "R4 unmasked");
        bus_wr(0, 3, 32'h0000_0000);
        bus_rd(0, 3, 32'h1, "R3 zero write no effect");
        bus_wr(0, 3, 32'h0000_0001);
        bus_rd(0, 3, 32'h0, "R3 one write clears");
        chk_irq(0, 1'b0, "R3 irq drops after clear");

        // R2: match already below count fires on the next edge
        bus_wr(2, 2, 32'h0000_FF07);
        chk_irq(2, 1'b0, "R2 not in the write cycle");
        @(negedge clk);
        chk_irq(2, 1'b1, "R2 one edge later");
        bus_wr(2, 2, 32'h0000_FF06);

        // R5: multi-step re-arm and zero step
        bus_wr(3, 0, 32'd100);
        bus_wr(3, 6, 32'd7);
        bus_wr(3, 4, 32'd50);
        bus_wr(1, 6, 32'd0);
        bus_wr(1, 4, 32'd40);
        bus_wr(1, 2, 32'h0000_000A);
        bus_wr(3, 2, 32'h0000_FF0B);
        repeat (4) @(negedge clk);
        bus_wr(3, 2, 32'h0000_FF0A);
        bus_rd(3, 4, 32'd106, "R5 match advanced by 8 steps");
        bus_rd(3, 3, 32'h1, "R5 event flagged");
        bus_rd(1, 4, 32'd40, "R5 zero step keeps match");
        bus_rd(1, 3, 32'h1, "R5 zero step still flags");

        // R8: map and unmapped word
        bus_rd(3, 6, 32'd7, "R8 step word");
        bus_rd(0, 7, 32'h0, "R8 unmapped read");
        bus_wr(0, 7, 32'hFFFF_FFFF);
        bus_rd(0, 7, 32'h0, "R8 unmapped after write");
        bus_rd(0, 2, 32'h0000_FF06, "R8 unmapped write left control");
        bus_rd(0, 0, 32'd100, "R8 unmapped write left count");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule